// File: doc/BRIEF.md
# Multiplexed Byte-Wide Register Bus Slave

This block gives a host access to a small bank of byte registers over one 8-bit bidirectional bus. Address and data share the bus. A phase select line marks each access as either an address cycle or a data cycle. The host uses active-low chip select, write and read strobes, and the block answers on an active-low ready line.

An address cycle stores the byte on the bus in an internal pointer. Every later data cycle reads or writes the register that the pointer selects. The pointer stays in place until the next address cycle. The strobes arrive asynchronously. The block passes them through two-flop synchronizers and detects their falling edges in its own clock domain.

The writable registers are presented to the surrounding logic as a flat vector. Byte k of that vector holds the register at offset k. One of these registers also serves as an interrupt enable mask. It combines with an event input to drive an active-low interrupt line.

Top module: `mbus_reg_slave`

## Requirements
- R1: A write strobe with `bus_sel` high (address phase) loads the data byte into the register pointer. Later data-phase accesses use that pointer until the next address write.
- R2: A write strobe with `bus_sel` low stores the data byte in the addressed register if that offset is writable. The writable offsets are 0x00, 0x01, 0x04 to 0x0A, 0x0C and 0x0D. The new value appears in byte k of `cfg_bytes` (bits 8k+7 to 8k) for offset k, and a later data-phase read returns it.
- R3: While chip select and read are low with `bus_sel` low, the block drives the addressed register's value onto `bus_data`.
- R4: While `bus_cs_n` is high, strobes have no effect. The pointer does not load, no register changes, and `bus_rdy_n` stays high.
- R5: `bus_rdy_n` falls on the third rising clock edge after a strobe goes low with chip select low. It rises on the third rising edge after both strobes are high again.
- R6: Offset 0x0F reads back the `REVISION` parameter. Writes to it are ignored.
- R7: Offsets not listed in R2 or R6 read as 0x00, and writes to them change no register. This includes any pointer value of 0x10 or above.
- R8: `irq_n` is low exactly when some bit is set in both `irq_src` and the register at offset 0x00.
- R9: After reset all registers are 0x00, the pointer is 0x00, and `bus_rdy_n` and `irq_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | Phase select: 1 = address cycle, 0 = data cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_data | inout | 8 | Shared address/data bus |
| bus_rdy_n | output | 1 | Ready handshake, active low |
| irq_n | output | 1 | Interrupt to host, active low |
| irq_src | input | 8 | Interrupt event bits from the register functions |
| cfg_bytes | output | 128 | Register contents; byte k is offset k, undecoded bytes are zero |

## Verification
The embedded assertions check several things on every clock:
- ready falls the cycle after a detected strobe edge;
- ready returns once both synchronized strobes are high;
- ready does not move while chip select is high;
- an address write loads the pointer;
- a decoded write takes the bus byte;
- an undecoded write leaves the register vector unchanged.

Only the bench's scenarios can show end-to-end behaviour: the full strobe-to-ready latency in clocks, the read data seen on the bus for every one of the 256 pointer values, the revision and zero readbacks, and the isolation of a deselected access.

// File: rtl/mbus_reg_slave.sv
module mbus_reg_slave #(
  parameter logic [7:0] REVISION = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_cs_n,
  input  logic         bus_sel,
  input  logic         bus_wr_n,
  input  logic         bus_rd_n,
  inout  wire  [7:0]   bus_data,
  output logic         bus_rdy_n,
  output logic         irq_n,
  input  logic [7:0]   irq_src,
  output logic [127:0] cfg_bytes
);
  localparam int NREG = 16;
  localparam int OW = $clog2(NREG);
  localparam logic [NREG-1:0] WR_MASK = 16'h37F3;
  localparam logic [OW-1:0] REV_OFS = OW'(NREG - 1);

  logic [2:0] cs_sh, wr_sh, rd_sh;
  logic [7:0] addr_q;
  logic [7:0] regs [NREG];
  logic [7:0] rdata;
  logic       rdy_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sh <= '1;
      wr_sh <= '1;
      rd_sh <= '1;
    end else begin
      cs_sh <= {cs_sh[1:0], bus_cs_n};
      wr_sh <= {wr_sh[1:0], bus_wr_n};
      rd_sh <= {rd_sh[1:0], bus_rd_n};
    end

  wire wr_ev = wr_sh[2] & ~wr_sh[1] & ~cs_sh[1];
  wire rd_ev = rd_sh[2] & ~rd_sh[1] & ~cs_sh[1];
  wire [OW-1:0] ofs = addr_q[OW-1:0];
  wire hit = (addr_q[7:OW] == '0);
  wire wr_ok = hit & WR_MASK[ofs];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (wr_ev) begin
      if (bus_sel) addr_q <= bus_data;
      else if (wr_ok) regs[ofs] <= bus_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdy_q <= 1'b1;
    else if (wr_ev | rd_ev) rdy_q <= 1'b0;
    else if (wr_sh[1] & rd_sh[1]) rdy_q <= 1'b1;

  always_comb begin
    rdata = 8'h00;
    if (wr_ok) rdata = regs[ofs];
    else if (hit && ofs == REV_OFS) rdata = REVISION;
  end

  always_comb
    for (int k = 0; k < NREG; k++)
      cfg_bytes[k*8 +: 8] = WR_MASK[k] ? regs[k] : 8'h00;

  assign bus_data  = (!bus_cs_n && !bus_rd_n && !bus_sel) ? rdata : 8'bz;
  assign bus_rdy_n = rdy_q;
  assign irq_n     = ~|(irq_src & regs[0]);

  AST_RDY_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev || rd_ev) |=> !bus_rdy_n); // R5
  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh[1] && rd_sh[1]) |=> bus_rdy_n); // R5
  AST_CS_GATES_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sh[1] && bus_rdy_n) |=> bus_rdy_n); // R4
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && bus_sel) |=> (addr_q == $past(bus_data))); // R1
  AST_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !bus_sel && wr_ok) |=> (rdata == $past(bus_data))); // R2
  AST_UNDECODED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !bus_sel && !wr_ok) |=> $stable(cfg_bytes)); // R7
endmodule

// File: tb/test_mbus_reg_slave.sv
module test_mbus_reg_slave;
  localparam logic [7:0] REV = 8'hA5;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sel = 0, wr_n = 1, rd_n = 1;
  logic tb_oe = 0;
  logic [7:0] tb_d = 0, irq_src = 0;
  wire  [7:0] bus_data;
  logic rdy_n, irq_n;
  logic [127:0] cfg_bytes;
  int vectors = 0, errors = 0;
  bit done = 0;

  assign bus_data = tb_oe ? tb_d : 8'bz;
  always #2 clk = ~clk;

  mbus_reg_slave #(.REVISION(REV)) i_mbus_reg_slave (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_sel(sel),
    .bus_wr_n(wr_n), .bus_rd_n(rd_n), .bus_data(bus_data),
    .bus_rdy_n(rdy_n), .irq_n(irq_n), .irq_src(irq_src), .cfg_bytes(cfg_bytes));

  function automatic bit decoded(input int a);
    return (a < 2) || (a >= 4 && a <= 10) || a == 12 || a == 13;
  endfunction
  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit is_addr, input bit is_rd, input logic [7:0] v,
                        output logic [7:0] got);
    int n;
    @(negedge clk);
    cs_n = 0; sel = is_addr;
    if (!is_rd) begin tb_oe = 1; tb_d = v; end
    if (is_rd) rd_n = 0; else wr_n = 0;
    n = 0;
    while (rdy_n && n < 12) begin @(negedge clk); n++; end
    check(n == 3, "R5 ready fall latency", n, 3);
    got = bus_data;
    wr_n = 1; rd_n = 1;
    n = 0;
    while (!rdy_n && n < 12) begin @(negedge clk); n++; end
    check(n == 3, "R5 ready rise latency", n, 3);
    tb_oe = 0; cs_n = 1; sel = 0;
  endtask

  task automatic wr_reg(input int a, input logic [7:0] v);
    logic [7:0] g;
    access(1, 0, 8'(a), g);
    access(0, 0, v, g);
  endtask

  task automatic rd_reg(input int a, output logic [7:0] v);
    logic [7:0] g;
    access(1, 0, 8'(a), g);
    access(0, 1, 8'h00, v);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, exp;
    int n;
    repeat (3) @(negedge clk);
    check(rdy_n === 1'b1, "R9 ready idle after reset", rdy_n, 1);
    check(irq_n === 1'b1, "R9 irq idle after reset", irq_n, 1);
    check(cfg_bytes == '0, "R9 registers zero after reset", cfg_bytes[31:0], 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    access(0, 1, 8'h00, got);
    check(got == 8'h00, "R9 pointer zero after reset", got, 0);

    for (int a = 0; a < 256; a++) wr_reg(a, pat(a));
    for (int a = 0; a < 256; a++) begin
      rd_reg(a, got);
      exp = (a < 16 && decoded(a)) ? pat(a) : (a == 15 ? REV : 8'h00);
      if (a < 16 && decoded(a)) check(got == exp, "R2 R3 readback", got, exp);
      else if (a == 15) check(got == exp, "R6 revision", got, exp);
      else check(got == exp, "R7 undecoded reads zero", got, exp);
    end
    for (int k = 0; k < 16; k++) begin
      exp = decoded(k) ? pat(k) : 8'h00;
      check(cfg_bytes[k*8 +: 8] == exp, "R2 R7 cfg_bytes content", cfg_bytes[k*8 +: 8], exp);
    end

    wr_reg(4, 8'h3C);
    access(0, 0, 8'hC3, got);
    rd_reg(5, got);
    check(got == pat(5), "R1 pointer held across data writes", got, pat(5));
    access(1, 0, 8'h04, got);
    access(0, 1, 8'h00, got);
    check(got == 8'hC3, "R1 second data write on held pointer", got, 8'hC3);

    @(negedge clk);
    sel = 1; tb_oe = 1; tb_d = 8'h06; wr_n = 0;
    for (n = 0; n < 6; n++) begin
      @(negedge clk);
      check(rdy_n === 1'b1, "R4 no ready without chip select", rdy_n, 1);
    end
    wr_n = 1; sel = 0; tb_d = 8'h77;
    repeat (4) @(negedge clk);
    wr_n = 0;
    repeat (6) @(negedge clk);
    wr_n = 1; tb_oe = 0;
    repeat (4) @(negedge clk);
    access(0, 1, 8'h00, got);
    check(got == 8'hC3, "R4 deselected strobes ignored", got, 8'hC3);

    for (int m = 0; m < 256; m += 17) begin
      wr_reg(0, 8'(m));
      for (int s = 0; s < 256; s += 13) begin
        @(negedge clk); irq_src = 8'(s);
        @(negedge clk);
        check(irq_n === !((m & s) != 0), "R8 interrupt mask", irq_n, !((m & s) != 0));
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule